// File: doc/BRIEF.md
# Capture-Compare PWM Timer

This block is a free-running up-counter of parameterised width (32 bits by default). It advances on a functional-clock enable, either on every enabled tick or once per power-of-two group of ticks through a prescaler. When it wraps past all-ones it either reloads from a load register or halts. A compare unit flags the moment the counter steps onto a programmed match value. A capture unit synchronises an external pin and latches the counter on the selected edges, into one register or into a pair of registers.

The overflow and compare events drive a waveform output. The output either toggles on each event or pulses away from its idle level for one cycle. The same three events (match, overflow, capture) set sticky status bits, which software clears by writing ones. An interrupt line and a wakeup line are each formed from the status and their own mask.

Software reaches every register through a single-cycle write port and a combinational read port in the block's own clock domain. One control word holds all mode settings.

Top module: `cc_pwm_timer`

## Requirements
- R1: After reset every register reads zero and pwmOut, irqOut and wakeOut are low. Word addresses are 0 control, 1 counter, 2 load, 3 reload trigger (reads zero), 4 match, 5 capture A, 6 capture B, 7 status, 8 enable-set, 9 enable-clear, 10 wake mask. Unused addresses read zero.
- R2: While control bit 0 is set and the prescaler is off, the counter increments by one on every cycle with tickEn high. Cycles with tickEn low leave it unchanged. With bit 0 clear the counter holds.
- R3: With control bit 5 set, the counter advances once per 2^(v+1) enabled ticks, where v is control bits 4:2.
- R4: An advance from all-ones sets status bit 1. The counter then takes the load value if control bit 1 is set. Otherwise it becomes zero and control bit 0 clears itself.
- R5: A write to address 1 loads the counter with the written data. A write of any data to address 3 copies the load register into the counter. Either write overrides the advance in that cycle.
- R6: With control bit 6 set, an advance whose new counter value equals the match register sets status bit 0.
- R7: capIn passes through two synchronising flops and is then edge-detected, so a change is acted on at the third clock edge after it. Control bits 9:8 select the edges: 01 rising, 10 falling, 11 both, 00 none. A selected edge copies the counter into capture A and sets status bit 2. Other edges have no effect.
- R8: With control bit 13 set, events alternate between capture A and capture B, starting with A. Status bit 2 is set only on the second event of each pair.
- R9: Control bits 11:10 choose the output trigger: 0 none, 1 overflow, 2 overflow or match (3 acts as none). With control bit 12 set, the output starts at the level in control bit 7 and toggles on each trigger. With bit 12 clear, the output sits at bit 7 and inverts for the one cycle after a trigger.
- R10: Writing a 1 to a status bit clears it. A new event in the same cycle wins over the clear. Writing ones to address 8 sets enable bits and writing ones to address 9 clears them; both addresses read the enables. irqOut is high while any status bit is set with its enable set.
- R11: wakeOut is high while any status bit is set with its bit in the wake mask (address 10) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Functional tick enable for counting |
| capIn | input | 1 | Asynchronous capture pin |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| pwmOut | output | 1 | Waveform output |
| irqOut | output | 1 | Interrupt request |
| wakeOut | output | 1 | Wakeup request |

## Verification
The bench runs the counter with a steady tick and with a gapped tick pattern, which separates advances gated by tickEn from advances per clock. A divide-by-four prescale run checks the tick grouping. Wrap tests are run with and without reload, to tell apart a reload, a halt and a stale start bit. Capture is driven with rising and falling pin changes under each edge setting, so that a missed edge and a wrongly accepted edge show up as different capture values. The paired-capture mode checks the A/B alternation and that status waits for the second event. Waveform tests cover toggle-on-match and a pulse-on-wrap around a high idle level, which separates toggle from pulse and shows whether the idle level is honoured.

// File: rtl/ccpt_pkg.sv
package ccpt_pkg;

  typedef enum logic [3:0] {
    ADDR_CTRL   = 4'd0,
    ADDR_COUNT  = 4'd1,
    ADDR_LOAD   = 4'd2,
    ADDR_RELOAD = 4'd3,
    ADDR_MATCH  = 4'd4,
    ADDR_CAPA   = 4'd5,
    ADDR_CAPB   = 4'd6,
    ADDR_STAT   = 4'd7,
    ADDR_ENSET  = 4'd8,
    ADDR_ENCLR  = 4'd9,
    ADDR_WAKE   = 4'd10
  } regAddr_e;

  // control word field positions
  localparam int BIT_START  = 0;
  localparam int BIT_AUTO   = 1;
  localparam int PRE_LO     = 2;
  localparam int PRE_W      = 3;
  localparam int BIT_PREEN  = 5;
  localparam int BIT_CMP    = 6;
  localparam int BIT_DEFLVL = 7;
  localparam int EDGE_LO    = 8;
  localparam int TRIG_LO    = 10;
  localparam int BIT_TOGGLE = 12;
  localparam int BIT_DUAL   = 13;
  localparam int CTRL_W     = 14;
  localparam int EVT_W      = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic cntWrite;
    logic reload;
  } dpStrobe_t;

  // events from datapath; packing order equals status bit order
  typedef struct packed {
    logic capture;
    logic overflow;
    logic match;
  } tmrEvent_t;

endpackage

// File: rtl/ccpt_datapath.sv
module ccpt_datapath
  import ccpt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              capIn,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] matchVal,
  input  logic [DATA_W-1:0] wdata,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] capA,
  output logic [DATA_W-1:0] capB,
  output tmrEvent_t         evt,
  output logic              pwmOut
);

  localparam int PRE_CNT_W = 1 << PRE_W;
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic             run, autoLd, preEn, cmpEn, defLvl, toggleMode, dualMode;
  logic [PRE_W-1:0] ptv;
  logic [1:0]       edgeSel, trigMode;

  assign run        = ctrlWord[BIT_START];
  assign autoLd     = ctrlWord[BIT_AUTO];
  assign ptv        = ctrlWord[PRE_LO +: PRE_W];
  assign preEn      = ctrlWord[BIT_PREEN];
  assign cmpEn      = ctrlWord[BIT_CMP];
  assign defLvl     = ctrlWord[BIT_DEFLVL];
  assign edgeSel    = ctrlWord[EDGE_LO +: 2];
  assign trigMode   = ctrlWord[TRIG_LO +: 2];
  assign toggleMode = ctrlWord[BIT_TOGGLE];
  assign dualMode   = ctrlWord[BIT_DUAL];

  // prescaler
  logic [PRE_CNT_W-1:0] preCnt, preLimit;
  logic [PRE_W:0]       preShift;
  logic                 preHit, advance;

  assign preShift = {1'b0, ptv} + 1'b1;
  assign preLimit = (PRE_CNT_W'(1) << preShift) - PRE_CNT_W'(1);
  assign preHit   = !preEn || (preCnt == preLimit);
  assign advance  = run && tickEn && preHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preCnt <= '0;
    else if (!run || !preEn) preCnt <= '0;
    else if (tickEn)         preCnt <= preHit ? '0 : preCnt + 1'b1;
  end

  // counter
  logic              atTop, swWrite;
  logic [DATA_W-1:0] nextAdv;

  assign atTop   = (count == ALL_ONES);
  assign nextAdv = atTop ? (autoLd ? loadVal : '0) : count + 1'b1;
  assign swWrite = strobe.cntWrite || strobe.reload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strobe.cntWrite) count <= wdata;
    else if (strobe.reload)   count <= loadVal;
    else if (advance)         count <= nextAdv;
  end

  assign evt.overflow = advance && atTop && !swWrite;
  assign evt.match    = advance && cmpEn && (nextAdv == matchVal) && !swWrite;

  // capture: two synchronising flops plus one history flop
  logic [1:0] capSync;
  logic       capPrev, rise, fall, capHit, dualPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSync <= '0;
      capPrev <= 1'b0;
    end else begin
      capSync <= {capSync[0], capIn};
      capPrev <= capSync[1];
    end
  end

  assign rise = capSync[1] && !capPrev;
  assign fall = !capSync[1] && capPrev;

  always_comb begin
    unique case (edgeSel)
      2'b01:   capHit = rise;
      2'b10:   capHit = fall;
      2'b11:   capHit = rise || fall;
      default: capHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA      <= '0;
      capB      <= '0;
      dualPhase <= 1'b0;
    end else begin
      if (capHit && (!dualMode || !dualPhase)) capA <= count;
      if (capHit && dualMode && dualPhase)     capB <= count;
      if (!dualMode)   dualPhase <= 1'b0;
      else if (capHit) dualPhase <= !dualPhase;
    end
  end

  assign evt.capture = capHit && (!dualMode || dualPhase);

  // waveform output
  logic pwmFire, pwmLevel, pulseQ;

  assign pwmFire = ((trigMode == 2'd1) && evt.overflow) ||
                   ((trigMode == 2'd2) && (evt.overflow || evt.match));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmLevel <= 1'b0;
      pulseQ   <= 1'b0;
    end else begin
      if (trigMode == 2'd0 || trigMode == 2'd3) pwmLevel <= defLvl;
      else if (pwmFire && toggleMode)           pwmLevel <= !pwmLevel;
      pulseQ <= pwmFire && !toggleMode;
    end
  end

  assign pwmOut = toggleMode ? pwmLevel : (defLvl ^ pulseQ);

  // R2: a stopped counter with no software write holds its value
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !swWrite) |=> $stable(count));

  // R5: a reload trigger copies the load register
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !strobe.cntWrite) |=> (count == $past(loadVal)));

  // R7: a single-mode capture latches the counter seen at the edge
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (capHit && !dualMode) |=> (capA == $past(count)));

endmodule

// File: rtl/ccpt_ctrl.sv
module ccpt_ctrl
  import ccpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] countVal,
  input  logic [DATA_W-1:0] capAVal,
  input  logic [DATA_W-1:0] capBVal,
  input  tmrEvent_t         evt,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] matchVal,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              wakeOut
);

  logic [EVT_W-1:0] statQ, enQ, wakeQ, evtBits, wMask;
  logic wrCtrl, wrLoad, wrMatch, wrStat, wrEnSet, wrEnClr, wrWake;

  assign evtBits = evt;
  assign wMask   = regWdata[EVT_W-1:0];

  assign wrCtrl  = regWe && (regAddr == ADDR_CTRL);
  assign wrLoad  = regWe && (regAddr == ADDR_LOAD);
  assign wrMatch = regWe && (regAddr == ADDR_MATCH);
  assign wrStat  = regWe && (regAddr == ADDR_STAT);
  assign wrEnSet = regWe && (regAddr == ADDR_ENSET);
  assign wrEnClr = regWe && (regAddr == ADDR_ENCLR);
  assign wrWake  = regWe && (regAddr == ADDR_WAKE);

  assign strobe.cntWrite = regWe && (regAddr == ADDR_COUNT);
  assign strobe.reload   = regWe && (regAddr == ADDR_RELOAD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                ctrlWord <= '0;
    else if (wrCtrl)                          ctrlWord <= regWdata[CTRL_W-1:0];
    else if (evt.overflow && !ctrlWord[BIT_AUTO]) ctrlWord[BIT_START] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal  <= '0;
      matchVal <= '0;
      statQ    <= '0;
      enQ      <= '0;
      wakeQ    <= '0;
    end else begin
      if (wrLoad)  loadVal  <= regWdata;
      if (wrMatch) matchVal <= regWdata;
      if (wrWake)  wakeQ    <= wMask;
      statQ <= (statQ & ~(wrStat ? wMask : '0)) | evtBits;
      enQ   <= (enQ | (wrEnSet ? wMask : '0)) & ~(wrEnClr ? wMask : '0);
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:  regRdata = DATA_W'(ctrlWord);
      ADDR_COUNT: regRdata = countVal;
      ADDR_LOAD:  regRdata = loadVal;
      ADDR_MATCH: regRdata = matchVal;
      ADDR_CAPA:  regRdata = capAVal;
      ADDR_CAPB:  regRdata = capBVal;
      ADDR_STAT:  regRdata = DATA_W'(statQ);
      ADDR_ENSET, ADDR_ENCLR: regRdata = DATA_W'(enQ);
      ADDR_WAKE:  regRdata = DATA_W'(wakeQ);
      default:    regRdata = '0;
    endcase
  end

  assign irqOut  = |(statQ & enQ);
  assign wakeOut = |(statQ & wakeQ);

  // R4: a wrap without reload stops the counter
  assert_halt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evt.overflow && !ctrlWord[BIT_AUTO] && !wrCtrl) |=> !ctrlWord[BIT_START]);

  // R10: write-one clears the addressed status bits when no event arrives
  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && (evtBits == '0)) |=> ((statQ & $past(wMask)) == '0));

endmodule

// File: rtl/cc_pwm_timer.sv
module cc_pwm_timer
  import ccpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              capIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              pwmOut,
  output logic              irqOut,
  output logic              wakeOut
);

  logic [CTRL_W-1:0] ctrlWord;
  logic [DATA_W-1:0] loadVal, matchVal, countVal, capAVal, capBVal;
  dpStrobe_t         strobe;
  tmrEvent_t         evt;

  ccpt_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .countVal(countVal), .capAVal(capAVal),
    .capBVal(capBVal), .evt(evt), .ctrlWord(ctrlWord), .loadVal(loadVal),
    .matchVal(matchVal), .strobe(strobe), .regRdata(regRdata),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  ccpt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capIn(capIn),
    .ctrlWord(ctrlWord), .loadVal(loadVal), .matchVal(matchVal),
    .wdata(regWdata), .strobe(strobe), .count(countVal), .capA(capAVal),
    .capB(capBVal), .evt(evt), .pwmOut(pwmOut)
  );

endmodule

// File: tb/cc_pwm_timer_tb.sv
`timescale 1ns/100ps
module cc_pwm_timer_tb;

  logic        clk = 0, rstN = 0, tickEn = 1, capIn = 0, regWe = 0;
  logic [3:0]  regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic        pwmOut, irqOut, wakeOut;
  int checks = 0, errors = 0;
  bit done = 0;

  cc_pwm_timer u_dut (.clk(clk), .rstN(rstN), .tickEn(tickEn), .capIn(capIn),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pwmOut(pwmOut), .irqOut(irqOut), .wakeOut(wakeOut));

  always #2.5 clk = !clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [13:0] mCtrl = 0;
  logic [31:0] mCount = 0, mLoad = 0, mMatch = 0, mCapA = 0, mCapB = 0, nCnt;
  logic [2:0]  mStat = 0, mEn = 0, mWake = 0, ev;
  logic        mPhase = 0, mLevel = 0, mPulse = 0, h0 = 0, h1 = 0, h2 = 0;
  logic        adv, ovf, mt, hit, capEv, fire;
  int          mPre = 0, mPreN, div;

  function automatic logic wAt(int a);
    return regWe && (regAddr == a[3:0]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mCount = 0; mLoad = 0; mMatch = 0; mCapA = 0; mCapB = 0;
      mStat = 0; mEn = 0; mWake = 0; mPhase = 0; mLevel = 0; mPulse = 0;
      h0 = 0; h1 = 0; h2 = 0; mPre = 0;
    end else begin
      div = 1 << (int'(mCtrl[4:2]) + 1);
      adv = mCtrl[0] && tickEn && (!mCtrl[5] || mPre == div - 1);
      if (!mCtrl[0] || !mCtrl[5]) mPreN = 0;
      else if (tickEn) mPreN = (mPre == div - 1) ? 0 : mPre + 1;
      else mPreN = mPre;
      ovf = 0; mt = 0; nCnt = mCount;
      if (wAt(1)) nCnt = regWdata;
      else if (wAt(3)) nCnt = mLoad;
      else if (adv) begin
        if (mCount == 32'hFFFF_FFFF) begin
          ovf = 1; nCnt = mCtrl[1] ? mLoad : 0;
        end else nCnt = mCount + 1;
        mt = mCtrl[6] && (nCnt == mMatch);
      end
      case (mCtrl[9:8])
        2'b01: hit = h1 && !h2;
        2'b10: hit = !h1 && h2;
        2'b11: hit = h1 != h2;
        default: hit = 0;
      endcase
      if (hit) begin
        if (!mCtrl[13] || !mPhase) mCapA = mCount; else mCapB = mCount;
      end
      capEv = hit && (!mCtrl[13] || mPhase);
      mPhase = mCtrl[13] ? (hit ? !mPhase : mPhase) : 0;
      fire = (mCtrl[11:10] == 1 && ovf) || (mCtrl[11:10] == 2 && (ovf || mt));
      if (mCtrl[11:10] == 0 || mCtrl[11:10] == 3) mLevel = mCtrl[7];
      else if (fire && mCtrl[12]) mLevel = !mLevel;
      mPulse = fire && !mCtrl[12];
      ev = {capEv, ovf, mt};
      mStat = (mStat & ~(wAt(7) ? regWdata[2:0] : 3'b0)) | ev;
      mEn = (mEn | (wAt(8) ? regWdata[2:0] : 3'b0)) & ~(wAt(9) ? regWdata[2:0] : 3'b0);
      if (wAt(10)) mWake = regWdata[2:0];
      if (wAt(2)) mLoad = regWdata;
      if (wAt(4)) mMatch = regWdata;
      if (wAt(0)) mCtrl = regWdata[13:0];
      else if (ovf && !mCtrl[1]) mCtrl[0] = 0;
      mCount = nCnt; mPre = mPreN;
      h2 = h1; h1 = h0; h0 = capIn;
    end
  end

  function automatic logic [31:0] expRead(logic [3:0] a);
    case (a)
      0: return {18'b0, mCtrl};
      1: return mCount;
      2: return mLoad;
      4: return mMatch;
      5: return mCapA;
      6: return mCapB;
      7: return {29'b0, mStat};
      8, 9: return {29'b0, mEn};
      10: return {29'b0, mWake};
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(logic [3:0] a);
    case (a)
      0: return "R4"; 1: return "R2"; 2, 3: return "R5"; 4: return "R6";
      5: return "R7"; 6: return "R8"; 7, 8, 9: return "R10"; 10: return "R11";
      default: return "R1";
    endcase
  endfunction

  // compare against the model on every cycle, between edges
  always @(negedge clk) begin
    #1.5;
    if (rstN && !done) begin
      chk({reqOf(regAddr), " read"}, regRdata, expRead(regAddr));
      chk("R9 pwmOut", {31'b0, pwmOut}, {31'b0, mCtrl[12] ? mLevel : (mCtrl[7] ^ mPulse)});
      chk("R10 irqOut", {31'b0, irqOut}, {31'b0, |(mStat & mEn)});
      chk("R11 wakeOut", {31'b0, wakeOut}, {31'b0, |(mStat & mWake)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a[3:0]; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    regAddr = a[3:0];
    #0.2;
    v = regRdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, v2;

  initial begin
    cyc(3);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, v); chk("R1 reset read", v, 0);
    end
    chk("R1 pwm", {31'b0, pwmOut}, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);

    // R2 counting, holding, gated ticks
    wr(1, 10); wr(0, 1); cyc(5);
    rd(1, v); chk("R2 count after 5", v, 15);
    wr(0, 0); rd(1, v); cyc(3); rd(1, v2);
    chk("R2 stopped holds", v2, v);
    wr(1, 0); wr(0, 1);
    for (int i = 0; i < 10; i++) begin
      tickEn = i[0]; @(negedge clk);
    end
    tickEn = 1; rd(1, v); chk("R2 gated ticks", v, 5);
    wr(0, 0);

    // R3 prescaler v=1 -> every 4 ticks
    wr(1, 0); wr(0, 32'h25); cyc(8);
    rd(1, v); chk("R3 prescaled count", v, 2);
    wr(0, 0);

    // R4 wrap with reload
    wr(1, 32'hFFFF_FFFE); wr(2, 100); wr(0, 3); cyc(2);
    rd(1, v); chk("R4 reload on wrap", v, 100);
    rd(7, v); chk("R4 overflow status", v, 2);
    wr(0, 0);
    // R4 wrap without reload
    wr(1, 32'hFFFF_FFFF); wr(0, 1); cyc(3);
    rd(1, v); chk("R4 wrap to zero", v, 0);
    rd(0, v); chk("R4 start cleared", v, 0);

    // R5 trigger reload
    wr(3, 123); rd(1, v); chk("R5 trigger reload", v, 100);

    // R10 interrupt plumbing
    chk("R10 masked irq", {31'b0, irqOut}, 0);
    wr(8, 2); chk("R10 enabled irq", {31'b0, irqOut}, 1);
    rd(8, v); chk("R10 enable read", v, 2);
    wr(7, 1); rd(7, v); chk("R10 clear other bit", v, 2);
    wr(7, 2); rd(7, v); chk("R10 w1c", v, 0);
    chk("R10 irq drops", {31'b0, irqOut}, 0);
    wr(9, 2); rd(9, v); chk("R10 enable clear", v, 0);

    // R6 compare
    wr(1, 0); wr(4, 5); wr(0, 32'h41); cyc(4);
    rd(7, v); chk("R6 no early match", v, 0);
    cyc(1); rd(7, v); chk("R6 match status", v, 1);
    wr(0, 0); wr(7, 7);

    // R9 toggle on match
    wr(1, 0); wr(4, 3); wr(0, 32'h1841);
    chk("R9 toggle idle", {31'b0, pwmOut}, 0);
    cyc(2); chk("R9 toggle before", {31'b0, pwmOut}, 0);
    cyc(1); chk("R9 toggled", {31'b0, pwmOut}, 1);
    wr(0, 0); wr(7, 7);
    // R9 pulse on wrap, idle high
    wr(1, 32'hFFFF_FFFD); wr(0, 32'h481);
    chk("R9 idle high", {31'b0, pwmOut}, 1);
    cyc(2); chk("R9 still high", {31'b0, pwmOut}, 1);
    cyc(1); chk("R9 pulse low", {31'b0, pwmOut}, 0);
    cyc(1); chk("R9 pulse ends", {31'b0, pwmOut}, 1);
    wr(0, 0); wr(7, 7);

    // R7 rising capture, counter stopped
    wr(1, 1000); wr(0, 32'h100);
    capIn = 1; cyc(2);
    rd(7, v); chk("R7 latency not yet", v, 0);
    cyc(1);
    rd(7, v); chk("R7 capture status", v, 4);
    rd(5, v); chk("R7 capture value", v, 1000);
    wr(7, 4); wr(1, 2000);
    capIn = 0; cyc(5);
    rd(5, v); chk("R7 falling ignored", v, 1000);
    rd(7, v); chk("R7 no status", v, 0);
    wr(0, 32'h200);
    capIn = 1; cyc(5);
    rd(5, v); chk("R7 rising ignored", v, 1000);
    capIn = 0; cyc(3);
    rd(5, v); chk("R7 falling capture", v, 2000);
    wr(7, 4);

    // R8 paired capture on both edges
    wr(0, 32'h2300); wr(1, 3000);
    capIn = 1; cyc(4);
    rd(5, v); chk("R8 first to A", v, 3000);
    rd(7, v); chk("R8 no status on first", v, 0);
    wr(1, 3001);
    capIn = 0; cyc(4);
    rd(6, v); chk("R8 second to B", v, 3001);
    rd(7, v); chk("R8 status on second", v, 4);

    // R11 wake mask
    wr(10, 4); chk("R11 wake high", {31'b0, wakeOut}, 1);
    chk("R11 irq masked", {31'b0, irqOut}, 0);
    wr(7, 4); chk("R11 wake low", {31'b0, wakeOut}, 0);

    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule